// File: doc/BRIEF.md
# Memory-Mapped 32x32 Multiplier

This peripheral sits on a 16-bit word bus and multiplies two 32-bit operands into a 64-bit product. Software loads each operand as two 16-bit halves through separate register writes. Then it reads the product back as four 16-bit words. The product can be unsigned or two's complement. Software picks the mode through the address it uses to write the low half of the first operand.

The second operand's upper half is the trigger. Writing it completes that operand and starts the multiply. The product registers load on the next clock edge. They then hold their value until the next trigger. Reads use the same synchronous port: a read request in one cycle returns its data on `rdata` after the following clock edge.

Top module: `mmio_mul32`

## Requirements
- R1: After reset, all four product words read as zero.
- R2: A write of the first operand's low half at offset 0x140 selects unsigned mode. A later multiply then yields the unsigned 64-bit product of the two 32-bit operands.
- R3: A write of the first operand's low half at offset 0x144 selects signed mode. Both operands are then treated as two's complement, and the product is a signed 64-bit value.
- R4: A write of the first operand's low half replaces the whole operand. Its upper 16 bits become zero.
- R5: A write at offset 0x142 or 0x146 sets the first operand's upper 16 bits. It keeps the existing low half and leaves the selected mode unchanged.
- R6: Offset 0x150 loads the second operand's low half. A write at offset 0x152 sets its upper half and starts the multiply.
- R7: The product registers take the new result on the clock edge after the edge that accepts the trigger write. A read issued in the cycle right after the trigger still returns the previous product.
- R8: Writes to any offset other than 0x152 leave the product unchanged.
- R9: The product is read at offsets 0x154, 0x156, 0x158 and 0x15A, least significant word first. Read data appears on `rdata` after the edge that accepts the read request. A read at any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | ADDR_W (9) | Word offset of the access |
| wdata | input | HALF_W (16) | Write data |
| rdata | output | HALF_W (16) | Registered read data |

## Verification
- **Write timing.** A write takes effect at the rising edge that samples it.
- **Product timing.** The product is due one edge after the trigger write.
- **Read timing.** A read's data is due one edge after the request.
- **How the bench drives and samples.** The bench drives every access on a falling edge. It samples `rdata` on the next falling edge. After each trigger it inserts one idle cycle before reading the product.
- **R7 check.** One check deliberately issues a read in the cycle right after a trigger. That read must still return the old product, which shows the result registers load exactly one edge later.

// File: rtl/mul32_pkg.sv
package mul32_pkg;

    // Register word offsets; the operand-one low address encodes the mode.
    localparam int OFS_A_LO_UNS = 'h140;
    localparam int OFS_A_HI_UNS = 'h142;
    localparam int OFS_A_LO_SGN = 'h144;
    localparam int OFS_A_HI_SGN = 'h146;
    localparam int OFS_B_LO     = 'h150;
    localparam int OFS_B_HI     = 'h152;
    localparam int OFS_P_BASE   = 'h154;

    typedef enum logic {
        MODE_UNS = 1'b0,
        MODE_SGN = 1'b1
    } mul_mode_e;

endpackage

// File: rtl/mul_addr_dec.sv
module mul_addr_dec #(
    parameter int ADDR_W = 9
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              a_lo_uns,
    output logic              a_lo_sgn,
    output logic              a_hi,
    output logic              b_lo,
    output logic              b_hi
);
    import mul32_pkg::*;

    always_comb begin
        a_lo_uns = wr_en && (addr == ADDR_W'(OFS_A_LO_UNS));
        a_lo_sgn = wr_en && (addr == ADDR_W'(OFS_A_LO_SGN));
        a_hi     = wr_en && ((addr == ADDR_W'(OFS_A_HI_UNS)) ||
                             (addr == ADDR_W'(OFS_A_HI_SGN)));
        b_lo     = wr_en && (addr == ADDR_W'(OFS_B_LO));
        b_hi     = wr_en && (addr == ADDR_W'(OFS_B_HI));
    end

endmodule

// File: rtl/mul_core.sv
module mul_core #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    input  logic              sgn,
    output logic [2*OP_W-1:0] p
);
    localparam int PROD_W = 2 * OP_W;

    logic [PROD_W-1:0] a_ext;
    logic [PROD_W-1:0] b_ext;

    // Sign or zero extension to the product width; the low PROD_W bits of
    // the extended product are correct in both modes.
    always_comb begin
        a_ext = {{OP_W{sgn & a[OP_W-1]}}, a};
        b_ext = {{OP_W{sgn & b[OP_W-1]}}, b};
        p     = a_ext * b_ext;
    end

endmodule

// File: rtl/mul_rdmux.sv
module mul_rdmux #(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 9,
    parameter int NWORDS = 4
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NWORDS*HALF_W-1:0] prod,
    output logic [HALF_W-1:0]        data
);
    import mul32_pkg::*;

    logic [HALF_W-1:0] part [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(OFS_P_BASE + 2 * w);
        assign part[w] = (addr == WADDR) ? prod[w*HALF_W +: HALF_W] : '0;
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < NWORDS; i++) begin
            data = data | part[i];
        end
    end

endmodule

// File: rtl/mmio_mul32.sv
module mmio_mul32 #(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata
);
    import mul32_pkg::*;

    localparam int OP_W   = 2 * HALF_W;
    localparam int PROD_W = 2 * OP_W;
    localparam int NWORDS = PROD_W / HALF_W;

    typedef struct packed {
        logic [OP_W-1:0]   op_a;
        logic [OP_W-1:0]   op_b;
        mul_mode_e         mode;
        logic              start;
        logic [PROD_W-1:0] prod;
        logic [HALF_W-1:0] rdata;
    } mul_state_t;

    mul_state_t s_d, s_q;

    logic              hit_a_lo_uns, hit_a_lo_sgn, hit_a_hi, hit_b_lo, hit_b_hi;
    logic [PROD_W-1:0] core_p;
    logic [HALF_W-1:0] mux_data;

    // Plain views of state used by the bound checker.
    logic              start_q;
    logic [PROD_W-1:0] prod_q;
    logic [OP_W-1:0]   op_a_q;
    logic              sgn_q;

    mul_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .a_lo_uns (hit_a_lo_uns),
        .a_lo_sgn (hit_a_lo_sgn),
        .a_hi     (hit_a_hi),
        .b_lo     (hit_b_lo),
        .b_hi     (hit_b_hi)
    );

    mul_core #(.OP_W(OP_W)) u_core (
        .a   (s_q.op_a),
        .b   (s_q.op_b),
        .sgn (s_q.mode == MODE_SGN),
        .p   (core_p)
    );

    mul_rdmux #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_rdmux (
        .addr (addr),
        .prod (s_q.prod),
        .data (mux_data)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;

        if (hit_a_lo_uns || hit_a_lo_sgn) begin
            s_d.op_a = OP_W'(wdata);
            s_d.mode = hit_a_lo_sgn ? MODE_SGN : MODE_UNS;
        end
        if (hit_a_hi) begin
            s_d.op_a[OP_W-1:HALF_W] = wdata;
        end
        if (hit_b_lo) begin
            s_d.op_b = OP_W'(wdata);
        end
        if (hit_b_hi) begin
            s_d.op_b[OP_W-1:HALF_W] = wdata;
            s_d.start               = 1'b1;
        end

        if (s_q.start) begin
            s_d.prod = core_p;
        end

        if (rd_en) begin
            s_d.rdata = mux_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata   = s_q.rdata;
    assign start_q = s_q.start;
    assign prod_q  = s_q.prod;
    assign op_a_q  = s_q.op_a;
    assign sgn_q   = (s_q.mode == MODE_SGN);

endmodule

// File: rtl/mmio_mul32_chk.sv
module mmio_mul32_chk #(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [HALF_W-1:0]   rdata,
    input logic                start_q,
    input logic [4*HALF_W-1:0] prod_q,
    input logic [2*HALF_W-1:0] op_a_q,
    input logic                sgn_q
);
    import mul32_pkg::*;

    logic in_prod_window;
    assign in_prod_window = (addr >= ADDR_W'(OFS_P_BASE)) &&
                            (addr <= ADDR_W'(OFS_P_BASE + 6)) && !addr[0];

    // R2: low write at the unsigned address clears the mode flag
    a_r2_mode_uns: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_A_LO_UNS)) |=> !sgn_q);

    // R3: low write at the signed address sets the mode flag
    a_r3_mode_sgn: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_A_LO_SGN)) |=> sgn_q);

    // R4: low write leaves the upper operand half zero
    a_r4_hi_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(OFS_A_LO_UNS) || addr == ADDR_W'(OFS_A_LO_SGN)))
        |=> (op_a_q[2*HALF_W-1:HALF_W] == '0));

    // R5: high-half write does not touch the mode
    a_r5_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(OFS_A_HI_UNS) || addr == ADDR_W'(OFS_A_HI_SGN)))
        |=> $stable(sgn_q));

    // R6: the trigger write raises the start pulse
    a_r6_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_B_HI)) |=> start_q);

    // R8: without a pending start the product holds
    a_r8_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |=> $stable(prod_q));

    // R9: reads outside the product words return zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_prod_window) |=> (rdata == '0));

endmodule

bind mmio_mul32 mmio_mul32_chk #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .start_q (start_q),
    .prod_q  (prod_q),
    .op_a_q  (op_a_q),
    .sgn_q   (sgn_q)
);

// File: tb/mmio_mul32_tb.sv
module mmio_mul32_tb;

    localparam logic [8:0] A_LO_U = 9'h140;
    localparam logic [8:0] A_HI_U = 9'h142;
    localparam logic [8:0] A_LO_S = 9'h144;
    localparam logic [8:0] A_HI_S = 9'h146;
    localparam logic [8:0] B_LO   = 9'h150;
    localparam logic [8:0] B_HI   = 9'h152;
    localparam logic [8:0] P_W0   = 9'h154;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    mmio_mul32 u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // All bus tasks start and end on a falling edge.
    task automatic bus_wr(input logic [8:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic check_prod(input string req, input logic [63:0] exp);
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            bus_rd(P_W0 + 9'(2 * i), v);
            check(req, v, exp[16*i +: 16]);
        end
    endtask

    task automatic load_and_run(input bit sgn, input logic [31:0] a, input logic [31:0] b);
        bus_wr(sgn ? A_LO_S : A_LO_U, a[15:0]);
        bus_wr(sgn ? A_HI_S : A_HI_U, a[31:16]);
        bus_wr(B_LO, b[15:0]);
        bus_wr(B_HI, b[31:16]);
        @(negedge clk);
    endtask

    function automatic logic [63:0] smul(input logic [31:0] a, input logic [31:0] b);
        longint x, y;
        x = longint'($signed(a));
        y = longint'($signed(b));
        return 64'(x * y);
    endfunction

    task automatic t_reset;
        logic [15:0] v;
        check_prod("R1", 64'h0);
        bus_rd(9'h100, v);
        check("R9 unmapped", v, 16'h0);
    endtask

    task automatic t_unsigned;
        load_and_run(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_prod("R2 max*max", 64'hFFFF_FFFE_0000_0001);
        load_and_run(1'b0, 32'h1234_5678, 32'h9ABC_DEF0);
        check_prod("R2 R9 pattern", {32'h0, 32'h1234_5678} * {32'h0, 32'h9ABC_DEF0});
    endtask

    task automatic t_signed;
        load_and_run(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_prod("R3 -1*-1", 64'h1);
        load_and_run(1'b1, 32'hFFFF_FFFE, 32'h0000_0003);
        check_prod("R3 -2*3", smul(32'hFFFF_FFFE, 32'h3));
        load_and_run(1'b1, 32'h8000_0000, 32'h8000_0000);
        check_prod("R3 min*min", 64'h4000_0000_0000_0000);
    endtask

    task automatic t_low_clears;
        bus_wr(A_HI_U, 16'hABCD);
        bus_wr(A_LO_U, 16'h0005);
        bus_wr(B_LO, 16'h0003);
        bus_wr(B_HI, 16'h0000);
        @(negedge clk);
        check_prod("R4", 64'd15);
    endtask

    task automatic t_high_keeps;
        bus_wr(A_LO_S, 16'h0002);
        bus_wr(A_HI_U, 16'hFFFF);
        bus_wr(B_LO, 16'h0003);
        bus_wr(B_HI, 16'h0000);
        @(negedge clk);
        check_prod("R5 R6", smul(32'hFFFF_0002, 32'h3));
    endtask

    task automatic t_timing_and_hold;
        logic [15:0] v;
        load_and_run(1'b0, 32'h0000_0007, 32'h0000_0006);
        bus_wr(A_LO_U, 16'h0009);
        bus_wr(B_LO, 16'h0009);
        bus_wr(B_HI, 16'h0000);
        bus_rd(P_W0, v);
        check("R7 old value", v, 16'd42);
        bus_rd(P_W0, v);
        check("R7 new value", v, 16'd81);
        bus_wr(A_LO_S, 16'h1111);
        bus_wr(A_HI_S, 16'h2222);
        bus_wr(B_LO, 16'h3333);
        bus_wr(9'h160, 16'hFFFF);
        @(negedge clk);
        check_prod("R8", 64'd81);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_low_clears();
        t_high_keeps();
        t_timing_and_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule